// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a serial data line together with a serial clock. A host places each byte in a one-byte holding register through a write strobe. The block copies the byte into a shift register and sends it one bit per clock period. While that happens the holding register is free, so the host can write the next byte. Two flags report progress. The empty flag says the holding register can take a new byte. The done flag says the line has gone quiet with nothing queued. Each flag has an enable, and the two interrupt request outputs are the flag ANDed with its enable.

The serial clock has two sources. In internal mode a divider produces it from the system clock. In external mode the block follows an incoming clock through a synchronizer. The serial clock idles high. Data changes after each falling edge and is stable at the next rising edge.

The empty flag is checked again while bit 7 goes out. If a byte is waiting at that point, the next frame follows with no gap. If nothing is waiting, the line stops and the done flag is raised.

Top module: `sst_tx`

## Requirements
- R1: After reset, hold_empty_o=1, tx_done_o=1, sclk_o=1 and sdata_o=1. irq_empty_o equals txe_irq_en_i and irq_done_o equals done_irq_en_i.
- R2: A cycle with wr_en_i=1 stores wr_data_i. In the next cycle hold_empty_o=0 and tx_done_o=0.
- R3: If tx_en_i=1, the line is idle and hold_empty_o=0, the byte is copied into the shift register and hold_empty_o returns to 1 in the next cycle. irq_empty_o always equals hold_empty_o AND txe_irq_en_i.
- R4: In internal mode (clk_src_i=0), each half period of sclk_o lasts div_i+1 clk_i cycles. A frame has exactly 8 low pulses, and the first falling edge comes div_i+1 cycles after the copy. sclk_o is high whenever no frame is running.
- R5: Bits leave least significant first, bit 0 through bit 7. sdata_o changes only together with a falling edge of sclk_o and holds across the next rising edge.
- R6: The empty flag is sampled at the falling edge that starts bit 7. If it is 0, the waiting byte is copied then, and the first falling edge of the next frame comes one half period after the bit-7 rising edge.
- R7: If the empty flag is 1 at the bit-7 falling edge, tx_done_o rises in that cycle. After the bit-7 rising edge, sclk_o stays high and sdata_o keeps the bit-7 level.
- R8: irq_done_o always equals tx_done_o AND done_irq_en_i.
- R9: A write in the same cycle as a copy sends the old byte. The new byte is kept as the next byte, so hold_empty_o is 0 afterwards.
- R10: In external mode (clk_src_i=1), sclk_o stays high. Each falling edge of ext_sclk_i puts the next bit on sdata_o within 3 clk_i cycles, and that level holds until the following falling edge.
- R11: While tx_en_i=0, no copy happens. Dropping tx_en_i stops the frame, and from the next cycle sclk_o=1 and sdata_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to write |
| tx_en_i | input | 1 | Transmit enable; low aborts the frame |
| txe_irq_en_i | input | 1 | Enable for the holding-empty request |
| done_irq_en_i | input | 1 | Enable for the transmit-done request |
| clk_src_i | input | 1 | 0 internal divider, 1 external clock |
| div_i | input | DIV_W | Half period minus one, in clk_i cycles |
| ext_sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data |
| hold_empty_o | output | 1 | Holding register can take a byte |
| tx_done_o | output | 1 | Line stopped with no byte queued |
| irq_empty_o | output | 1 | Holding-empty interrupt request |
| irq_done_o | output | 1 | Transmit-done interrupt request |

## Verification
Two events can fall in the same clock edge: a host write, and the copy made at the bit-7 falling edge. The bench uses its reference model to find the cycle just before that falling edge and puts the write strobe there. It then checks that the copied byte is the older one and that the newer byte goes out in the following frame with no gap. It also checks that the empty flag reads 0 right after that edge. A separate scenario measures the bit-7-to-next-frame gap of a chained transfer in clk_i cycles and checks that an abort returns both pins to idle.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } sclk_src_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_DIV_W  = 8;
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             phase_hi_i,
  input  logic             ext_mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_sclk_i,
  output logic             fall_tick_o,
  output logic             rise_tick_o
);
  localparam int unsigned LAST = SYNC_STAGES;

  logic [DIV_W-1:0] cnt_q;
  logic [LAST:0]    sync_q;
  logic             int_tick, ext_fall, ext_rise;

  // synchronizer stages plus one history stage for edge detect
  for (genvar g = 0; g <= LAST; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= ext_sclk_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign ext_fall = sync_q[LAST] & ~sync_q[LAST-1];
  assign ext_rise = ~sync_q[LAST] & sync_q[LAST-1];

  assign int_tick = active_i & ~ext_mode_i & (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!active_i || ext_mode_i) cnt_q <= '0;
    else if (cnt_q == div_i)          cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign fall_tick_o = ext_mode_i ? ext_fall : (int_tick & phase_hi_i);
  assign rise_tick_o = ext_mode_i ? ext_rise : (int_tick & ~phase_hi_i);

  assert_tick_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_tick |=> (!int_tick || div_i == '0));
endmodule

// File: rtl/sst_hold.sv
module sst_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              copy_i,
  input  logic              set_done_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              empty_o,
  output logic              done_o
);
  logic [DATA_W-1:0] hold_q;
  logic              empty_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else if (wr_en_i) begin
      // write wins over a same-cycle copy: copy takes the old byte
      hold_q  <= wr_data_i;
      empty_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (copy_i)     empty_q <= 1'b1;
      if (set_done_i) done_q  <= 1'b1;
    end
  end

  assign hold_o  = hold_q;
  assign empty_o = empty_q;
  assign done_o  = done_q;

  assert_wr_clears_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!empty_q && !done_q));

  assert_done_with_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> empty_q);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              fall_tick_i,
  input  logic              rise_tick_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              active_o,
  output logic              phase_hi_o,
  output logic              sdata_o,
  output logic              copy_o,
  output logic              set_done_o
);
  localparam int unsigned       IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  bit_q;
  logic              active_q, phase_q, sdata_q, chain_q;
  logic              fall_ok, rise_ok, at_last, start;

  assign fall_ok = active_q & phase_q & fall_tick_i;
  assign rise_ok = active_q & ~phase_q & rise_tick_i;
  assign at_last = (bit_q == LAST_IDX);
  assign start   = tx_en_i & ~active_q & ~empty_i;

  assign copy_o     = start | (tx_en_i & fall_ok & at_last & ~empty_i);
  assign set_done_o = tx_en_i & fall_ok & at_last & empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      bit_q    <= '0;
      active_q <= 1'b0;
      phase_q  <= 1'b1;
      sdata_q  <= 1'b1;
      chain_q  <= 1'b0;
    end else if (!tx_en_i) begin
      active_q <= 1'b0;
      phase_q  <= 1'b1;
      sdata_q  <= 1'b1;
      chain_q  <= 1'b0;
      bit_q    <= '0;
    end else if (!active_q) begin
      if (start) begin
        shreg_q  <= hold_i;
        bit_q    <= '0;
        active_q <= 1'b1;
      end
    end else if (fall_ok) begin
      phase_q <= 1'b0;
      sdata_q <= shreg_q[bit_q];
      if (at_last) begin
        // re-check for a waiting byte while the last bit goes out
        chain_q <= ~empty_i;
        if (!empty_i) shreg_q <= hold_i;
      end
    end else if (rise_ok) begin
      phase_q <= 1'b1;
      if (at_last) begin
        bit_q    <= '0;
        active_q <= chain_q;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign active_o   = active_q;
  assign phase_hi_o = phase_q;
  assign sdata_o    = sdata_q;

  assert_idle_clock_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> phase_q);

  assert_abort_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (!active_q && phase_q && sdata_q));
endmodule

// File: rtl/sst_tx.sv
module sst_tx
  import sst_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned DIV_W       = DEF_DIV_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              txe_irq_en_i,
  input  logic              done_irq_en_i,
  input  logic              clk_src_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              ext_sclk_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              hold_empty_o,
  output logic              tx_done_o,
  output logic              irq_empty_o,
  output logic              irq_done_o
);
  logic [DATA_W-1:0] hold;
  logic              empty, done, active, phase_hi, fall_tick, rise_tick, copy, set_done;
  logic              ext_mode;

  assign ext_mode = (sclk_src_e'(clk_src_i) == SRC_EXTERNAL);

  sst_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk_i, .rst_ni,
    .active_i   (active),
    .phase_hi_i (phase_hi),
    .ext_mode_i (ext_mode),
    .div_i,
    .ext_sclk_i,
    .fall_tick_o(fall_tick),
    .rise_tick_o(rise_tick)
  );

  sst_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_data_i,
    .copy_i     (copy),
    .set_done_i (set_done),
    .hold_o     (hold),
    .empty_o    (empty),
    .done_o     (done)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i, .rst_ni, .tx_en_i,
    .fall_tick_i(fall_tick),
    .rise_tick_i(rise_tick),
    .empty_i    (empty),
    .hold_i     (hold),
    .active_o   (active),
    .phase_hi_o (phase_hi),
    .sdata_o,
    .copy_o     (copy),
    .set_done_o (set_done)
  );

  // pin is an input in external mode, so the driven clock parks high
  assign sclk_o       = ext_mode ? 1'b1 : phase_hi;
  assign hold_empty_o = empty;
  assign tx_done_o    = done;
  assign irq_empty_o  = empty & txe_irq_en_i;
  assign irq_done_o   = done & done_irq_en_i;

  assert_data_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $past(tx_en_i) && !ext_mode && !$stable(sdata_o)) |-> $fell(sclk_o));
endmodule

// File: tb/sst_tx_tb.sv
`timescale 1ns/1ps
module sst_tx_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_en = 1'b0, tie = 1'b1, teie = 1'b0, clk_src = 1'b0, ext_sclk = 1'b1;
  logic [7:0] div = 8'd2;
  logic       sclk_o, sdata_o, hold_empty_o, tx_done_o, irq_empty_o, irq_done_o;

  always #2 clk = ~clk;

  sst_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_i(tx_en), .txe_irq_en_i(tie), .done_irq_en_i(teie),
    .clk_src_i(clk_src), .div_i(div), .ext_sclk_i(ext_sclk),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .hold_empty_o(hold_empty_o),
    .tx_done_o(tx_done_o), .irq_empty_o(irq_empty_o), .irq_done_o(irq_done_o)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  bit m_act, m_sclk, m_sdata, m_empty, m_tend, m_chain, model_on = 1'b1;
  int m_cnt, m_bit;
  logic [7:0] m_sh, m_hold;

  always @(posedge clk) begin : ref_model
    bit tick, cp, sd;
    if (!rst_ni) begin
      m_act = 0; m_sclk = 1; m_sdata = 1; m_empty = 1; m_tend = 1; m_chain = 0;
      m_cnt = 0; m_bit = 0; m_sh = 0; m_hold = 0;
    end else begin
      cp = 0; sd = 0;
      tick = m_act && (m_cnt == int'(div));
      if (!tx_en) begin
        m_act = 0; m_sclk = 1; m_sdata = 1; m_chain = 0; m_bit = 0; m_cnt = 0;
      end else if (!m_act) begin
        m_cnt = 0;
        if (!m_empty) begin m_sh = m_hold; cp = 1; m_act = 1; m_bit = 0; end
      end else begin
        m_cnt = tick ? 0 : m_cnt + 1;
        if (tick && m_sclk) begin
          m_sclk = 0; m_sdata = m_sh[m_bit];
          if (m_bit == 7) begin
            m_chain = !m_empty;
            if (!m_empty) begin m_sh = m_hold; cp = 1; end
            else sd = 1;
          end
        end else if (tick && !m_sclk) begin
          m_sclk = 1;
          if (m_bit == 7) begin m_bit = 0; m_act = m_chain; end
          else m_bit++;
        end
      end
      if (wr_en) begin m_hold = wr_data; m_empty = 0; m_tend = 0; end
      else begin
        if (cp) m_empty = 1;
        if (sd) m_tend = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      chk(sclk_o == m_sclk, "R4", "sclk_o", sclk_o, m_sclk);
      chk(sdata_o == m_sdata, "R5", "sdata_o", sdata_o, m_sdata);
      chk(hold_empty_o == m_empty, "R3", "hold_empty_o", hold_empty_o, m_empty);
      chk(tx_done_o == m_tend, "R7", "tx_done_o", tx_done_o, m_tend);
      chk(irq_empty_o == (m_empty & tie), "R3", "irq_empty_o", irq_empty_o, m_empty & tie);
      chk(irq_done_o == (m_tend & teie), "R8", "irq_done_o", irq_done_o, m_tend & teie);
    end
  end

  // line receiver: samples on sclk_o rising edges
  logic [7:0] rx_b;
  int rx_n = 0;
  bit prev_sclk = 1, gap_probe = 0;
  longint last_rise = 0;
  logic [7:0] rx_q[$], exp_q[$];

  always @(negedge clk) begin
    if (!tx_en || clk_src) rx_n = 0;
    else if (!prev_sclk && sclk_o) begin
      rx_b[rx_n] = sdata_o;
      rx_n++;
      last_rise = cyc;
      if (rx_n == 8) begin rx_q.push_back(rx_b); rx_n = 0; end
    end else if (prev_sclk && !sclk_o && gap_probe && rx_n == 0) begin
      chk(cyc - last_rise == longint'(div) + 1, "R6", "chained gap",
          int'(cyc - last_rise), int'(div) + 1);
    end
    prev_sclk = sclk_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic drv; @(negedge clk); #1; endtask
  task automatic step(input int n); repeat (n) @(negedge clk); endtask

  task automatic write_byte(input logic [7:0] b, input bit expect_tx);
    drv(); wr_en = 1; wr_data = b;
    drv(); wr_en = 0;
    if (expect_tx) exp_q.push_back(b);
  endtask

  task automatic wait_idle;
    int n = 0;
    while (!(tx_done_o && hold_empty_o && sclk_o) && n < 5000) begin step(1); n++; end
    step(int'(div) + 4);
  endtask

  task automatic wait_empty;
    int n = 0;
    while (!hold_empty_o && n < 5000) begin step(1); n++; end
  endtask

  initial begin
    // R1: reset state
    step(3);
    chk(sclk_o == 1 && sdata_o == 1, "R1", "pins in reset", {sclk_o, sdata_o}, 2'b11);
    chk(hold_empty_o == 1 && tx_done_o == 1, "R1", "flags in reset",
        {hold_empty_o, tx_done_o}, 2'b11);
    chk(irq_empty_o == 1 && irq_done_o == 0, "R1", "irqs in reset",
        {irq_empty_o, irq_done_o}, 2'b10);
    drv(); rst_ni = 1;

    // R11: a byte written while disabled is not sent; R2 flag clear
    write_byte(8'h5A, 1);
    chk(hold_empty_o == 0 && tx_done_o == 0, "R2", "flags after write",
        {hold_empty_o, tx_done_o}, 2'b00);
    step(20);
    chk(sclk_o == 1 && hold_empty_o == 0, "R11", "no copy while disabled",
        {sclk_o, hold_empty_o}, 2'b10);
    drv(); tx_en = 1;
    wait_idle();

    // R6: back-to-back frames with gap probe
    teie = 1;
    write_byte(8'hA5, 1);
    while (sclk_o) step(1);
    while (!sclk_o) step(1);
    gap_probe = 1;
    wait_empty();
    write_byte(8'h3C, 1);
    wait_empty();
    write_byte(8'hC3, 1);
    wait_idle();
    gap_probe = 0;
    chk(tx_done_o == 1 && irq_done_o == 1, "R8", "done irq after chain",
        {tx_done_o, irq_done_o}, 2'b11);

    // R9: write collides with the bit-7 copy
    tie = 0;
    write_byte(8'h11, 1);
    wait_empty();
    write_byte(8'h22, 1);
    begin
      int n = 0;
      while (!(m_act && m_sclk && m_bit == 7 && m_cnt == int'(div) && !m_empty)
             && n < 5000) begin @(negedge clk); n++; end
    end
    #1; wr_en = 1; wr_data = 8'h33; exp_q.push_back(8'h33);
    drv(); wr_en = 0;
    chk(hold_empty_o == 0, "R9", "byte kept after collision", hold_empty_o, 0);
    wait_idle();

    // R4: divider corners
    tie = 1;
    drv(); div = 8'd0;
    write_byte(8'h81, 1);
    wait_idle();
    drv(); div = 8'd5;
    write_byte(8'h7E, 1);
    wait_idle();

    // R11: abort mid-frame
    write_byte(8'hF0, 0);
    begin
      int falls = 0;
      bit p = 1;
      while (falls < 3) begin
        @(negedge clk);
        if (p && !sclk_o) falls++;
        p = sclk_o;
      end
    end
    #1; tx_en = 0;
    step(1);
    chk(sclk_o == 1 && sdata_o == 1, "R11", "pins idle after abort",
        {sclk_o, sdata_o}, 2'b11);
    step(6);
    drv(); tx_en = 1;
    step(30);
    chk(sclk_o == 1, "R11", "no restart after abort", sclk_o, 1);

    // R5: byte stream order and content
    chk(rx_q.size() == exp_q.size(), "R5", "frame count", rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp_q[i], "R5", "received byte", rx_q[i], exp_q[i]);

    // R10: external clock mode
    model_on = 0;
    drv(); clk_src = 1;
    write_byte(8'h96, 0);
    step(5);
    begin
      logic [7:0] got = 8'h00;
      for (int i = 0; i < 8; i++) begin
        drv(); ext_sclk = 0;
        step(6);
        got[i] = sdata_o;
        chk(sclk_o == 1, "R10", "sclk_o parked", sclk_o, 1);
        drv(); ext_sclk = 1;
        step(6);
        chk(sdata_o == got[i], "R10", "bit held over rise", sdata_o, got[i]);
      end
      chk(got == 8'h96, "R10", "external byte", got, 8'h96);
    end
    step(4);
    chk(tx_done_o == 1 && hold_empty_o == 1, "R7", "done after external frame",
        {tx_done_o, hold_empty_o}, 2'b11);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule